// File: doc/BRIEF.md
# MDIO Wide Register Bridge

The bridge sits behind an MDIO slave whose serial framing is already decoded into a PHY address, a register number, write data and a one-cycle request strobe. It lets a host that can only issue 16-bit clause-22 transfers reach a 32-bit internal register space. Each 32-bit register is split into a low half and a high half, which sit on an even/odd pair of MDIO register numbers. Registers are spread over a window of eight PHY addresses. The upper word-address bits come from a page value held in the bridge.

The host first writes the page to PHY 31, register 16. A write to an odd (high-half) register is only held inside the bridge. The following write to the even (low-half) register issues a single 32-bit write that carries both halves. A read of the even register issues a single 32-bit read, returns its low half and keeps its high half. A read of the odd register then returns the kept value, so the two halves always come from the same bus read.

The internal side is a simple request/ready register bus with a byte address. While a bus access is waiting for ready, the bridge reports busy and drops any new MDIO request.

Top module: `mdio_wide_reg_bridge`

## Requirements
- R1: After a synchronous active-low reset, `bus_req`, `busy` and `mdio_rvalid` are low and `mdio_rdata` is zero. The page and the staged upper half are both zero, so a low-half write with no earlier high-half write carries zero in bits 31:16.
- R2: A write to PHY 0x1F register 0x10 stores write-data bits 8:0 as the page. A read of that register returns the page zero-extended to 16 bits.
- R3: For PHY addresses 0x10 to 0x17, the bus byte address is {page, PHY[2:0], REG[4:1], 2'b00}. Bits 17:9 therefore come from the page and bits 1:0 are always zero.
- R4: A write to an odd register in the window stores the data as the staged upper half and starts no bus access.
- R5: A write to an even register in the window starts exactly one bus write, with `bus_wdata` = {staged upper half, write data}.
- R6: A read of an even register in the window starts exactly one bus read. It returns `bus_rdata[15:0]` and keeps `bus_rdata[31:16]` as the held upper half.
- R7: A read of an odd register in the window starts no bus access. It returns the held upper half with `mdio_rvalid` in the cycle after the request.
- R8: `bus_req` is raised in the cycle after an accepted low-half access. It stays high, with address, direction and data unchanged, until the cycle after `bus_ready`. `busy` is high throughout. A low-half read answers with `mdio_rvalid` in the cycle after `bus_ready`.
- R9: A request presented while `busy` is high is dropped. It changes neither the page nor the staged half, and it produces no bus access and no response.
- R10: Every access outside the window and the page register (other PHY addresses, and other registers of PHY 0x1F) is ignored when it is a write. When it is a read, it returns zero with `mdio_rvalid` in the next cycle.
- R11: Every accepted read produces exactly one `mdio_rvalid` pulse. A write produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdio_req | input | 1 | One-cycle strobe for a decoded MDIO access |
| mdio_wr | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | Decoded PHY address |
| mdio_reg | input | 5 | Decoded register number |
| mdio_wdata | input | 16 | Write data |
| mdio_rvalid | output | 1 | Read response strobe |
| mdio_rdata | output | 16 | Read response data |
| busy | output | 1 | Bus access in flight; requests are dropped |
| bus_req | output | 1 | Internal bus request, held until ready |
| bus_we | output | 1 | Internal bus direction, 1 = write |
| bus_addr | output | 18 | Internal byte address, word aligned |
| bus_wdata | output | 32 | Internal write data |
| bus_ready | input | 1 | Internal bus completion |
| bus_rdata | input | 32 | Internal read data, valid with ready |

## Verification
The hardest case to reach from the ports is a request that arrives while a bus access is stalled. The driver normally waits for `busy` to fall, so the bench sets a long ready latency on its bus responder, starts a low-half write and then drives a high-half write and a read straight onto the ports while `busy` is high. The next low-half write must still carry the earlier staged half. No extra bus access and no extra response may appear; the monitor would see either one as a handshake or a strobe with nothing queued for it. Zero latency and varied latencies cover both ends of the handshake.

// File: rtl/mdio_bridge_pkg.sv
// Package: mdio_bridge_pkg
// Constants of the paged address split and the types shared by the bridge
// and its checker. The split widths are fixed by the clause-22 frame:
// 5-bit PHY and register numbers and 16-bit data.
package mdio_bridge_pkg;

    localparam int MDIO_ADDR_W = 5;
    localparam int HALF_W      = 16;
    localparam int WORD_W      = 2 * HALF_W;
    localparam int WIN_SEL_W   = 3;     // PHY bits that select a word group
    localparam int PAIR_SEL_W  = 4;     // register bits that select a pair
    localparam int BYTE_OFS_W  = 2;     // byte offset dropped for word alignment
    localparam int WIN_TAG_W   = MDIO_ADDR_W - WIN_SEL_W;

    localparam logic [MDIO_ADDR_W-1:0] PAGE_PHY    = 5'h1F;
    localparam logic [MDIO_ADDR_W-1:0] PAGE_REGNUM = 5'h10;
    localparam logic [WIN_TAG_W-1:0]   WIN_TAG     = 2'b10;  // PHY 0x10..0x17

    // Kind of an MDIO access after decoding
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PAGE = 2'd1,
        ACC_LOW  = 2'd2,
        ACC_HIGH = 2'd3
    } acc_kind_e;

    // State of the internal bus sequencer
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/mdio_win_decode.sv
// Module: mdio_win_decode
// Sorts a decoded MDIO access into page, low-half, high-half or ignored,
// and forms the word-aligned internal byte address from the page and the
// PHY/register numbers. Purely combinational.
// Assumes: the page register is the only decoded register of PHY 0x1F.
module mdio_win_decode
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int ADDR_W = PAGE_W + WIN_SEL_W + PAIR_SEL_W + BYTE_OFS_W
) (
    input  logic [MDIO_ADDR_W-1:0] phy,
    input  logic [MDIO_ADDR_W-1:0] regnum,
    input  logic [PAGE_W-1:0]      page,
    output acc_kind_e              kind,
    output logic [ADDR_W-1:0]      addr
);

    logic in_window;
    logic is_page;

    // Classify the PHY/register pair
    always_comb begin
        in_window = (phy[MDIO_ADDR_W-1:WIN_SEL_W] == WIN_TAG);
        is_page   = (phy == PAGE_PHY) && (regnum == PAGE_REGNUM);
        if (is_page) begin
            kind = ACC_PAGE;
        end else if (in_window && regnum[0]) begin
            kind = ACC_HIGH;
        end else if (in_window) begin
            kind = ACC_LOW;
        end else begin
            kind = ACC_NONE;
        end
    end

    // Assemble page, group select and pair select into a byte address
    always_comb begin
        addr = {page,
                phy[WIN_SEL_W-1:0],
                regnum[PAIR_SEL_W:1],
                {BYTE_OFS_W{1'b0}}};
    end

endmodule

// File: rtl/mdio_hold_regs.sv
// Module: mdio_hold_regs
// Keeps the three values that the 16-bit host side leaves behind between
// transfers: the page, the upper half staged by a high-half write and the
// upper half kept from the last low-half read.
// Assumes: load strobes are single-cycle and already qualified.
module mdio_hold_regs
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_load,
    input  logic              stage_load,
    input  logic [HALF_W-1:0] host_wdata,
    input  logic              hold_load,
    input  logic [HALF_W-1:0] bus_upper,
    output logic [PAGE_W-1:0] page,
    output logic [HALF_W-1:0] staged_hi,
    output logic [HALF_W-1:0] held_hi
);

    // Page value from the page register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (page_load) begin
            page <= host_wdata[PAGE_W-1:0];
        end
    end

    // Upper half waiting for its low-half write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_hi <= '0;
        end else if (stage_load) begin
            staged_hi <= host_wdata;
        end
    end

    // Upper half of the last completed bus read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_hi <= '0;
        end else if (hold_load) begin
            held_hi <= bus_upper;
        end
    end

endmodule

// File: rtl/mdio_bus_seq.sv
// Module: mdio_bus_seq
// Runs one internal bus access at a time with a request/ready handshake.
// The request and its address, direction and data are registered and held
// until ready is seen. A one-cycle pulse marks the completion of a read.
// Assumes: start is only raised while busy is low.
module mdio_bus_seq
    import mdio_bridge_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    output logic              busy,
    output logic              rd_done
);

    seq_state_e state;

    // Handshake state: idle until started, waiting until ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE: if (start)     state <= SEQ_WAIT;
                SEQ_WAIT: if (bus_ready) state <= SEQ_IDLE;
                default:                 state <= SEQ_IDLE;
            endcase
        end
    end

    // Request strobe follows the waiting state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req <= 1'b0;
        end else if (state == SEQ_IDLE) begin
            bus_req <= start;
        end else if (bus_ready) begin
            bus_req <= 1'b0;
        end
    end

    // Capture address, direction and data once per access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (state == SEQ_IDLE && start) begin
            bus_we    <= start_we;
            bus_addr  <= start_addr;
            bus_wdata <= start_wdata;
        end
    end

    // Status to the host side
    always_comb begin
        busy    = (state == SEQ_WAIT);
        rd_done = (state == SEQ_WAIT) && bus_ready && !bus_we;
    end

endmodule

// File: rtl/mdio_wide_reg_bridge.sv
// Module: mdio_wide_reg_bridge
// Bridges decoded 16-bit MDIO accesses onto a 32-bit request/ready
// register bus. A page register supplies the upper address bits, eight PHY
// addresses and even/odd register pairs supply the rest. A high-half write
// is staged and committed by the low-half write. A low-half read fetches the
// whole word and keeps the upper half for the high-half read.
// Assumes: the MDIO framing is decoded upstream. The host writes high then
// low, and reads low then high.
module mdio_wide_reg_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 9,
    localparam int ADDR_W = PAGE_W + WIN_SEL_W + PAIR_SEL_W + BYTE_OFS_W,
    localparam int DATA_W = WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mdio_req,
    input  logic                   mdio_wr,
    input  logic [MDIO_ADDR_W-1:0] mdio_phy,
    input  logic [MDIO_ADDR_W-1:0] mdio_reg,
    input  logic [HALF_W-1:0]      mdio_wdata,
    output logic                   mdio_rvalid,
    output logic [HALF_W-1:0]      mdio_rdata,
    output logic                   busy,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_ready,
    input  logic [DATA_W-1:0]      bus_rdata
);

    acc_kind_e          kind;
    logic [ADDR_W-1:0]  acc_addr;
    logic [PAGE_W-1:0]  page;
    logic [HALF_W-1:0]  staged_hi;
    logic [HALF_W-1:0]  held_hi;
    logic               accept;
    logic               rd_done;
    logic               start_bus;
    logic [HALF_W-1:0]  page_ext;

    // Accepted request and the derived strobes
    always_comb begin
        accept    = mdio_req && !busy;
        start_bus = accept && (kind == ACC_LOW);
        page_ext  = HALF_W'(page);
    end

    mdio_win_decode #(
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .phy    (mdio_phy),
        .regnum (mdio_reg),
        .page   (page),
        .kind   (kind),
        .addr   (acc_addr)
    );

    mdio_hold_regs #(
        .PAGE_W (PAGE_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_load  (accept && mdio_wr && (kind == ACC_PAGE)),
        .stage_load (accept && mdio_wr && (kind == ACC_HIGH)),
        .host_wdata (mdio_wdata),
        .hold_load  (rd_done),
        .bus_upper  (bus_rdata[DATA_W-1:HALF_W]),
        .page       (page),
        .staged_hi  (staged_hi),
        .held_hi    (held_hi)
    );

    mdio_bus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_bus),
        .start_we    (mdio_wr),
        .start_addr  (acc_addr),
        .start_wdata ({staged_hi, mdio_wdata}),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .busy        (busy),
        .rd_done     (rd_done)
    );

    // Read response: bus low half, page, held upper half or zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_rvalid <= 1'b0;
            mdio_rdata  <= '0;
        end else begin
            mdio_rvalid <= 1'b0;
            if (rd_done) begin
                mdio_rvalid <= 1'b1;
                mdio_rdata  <= bus_rdata[HALF_W-1:0];
            end else if (accept && !mdio_wr && (kind != ACC_LOW)) begin
                mdio_rvalid <= 1'b1;
                case (kind)
                    ACC_PAGE: mdio_rdata <= page_ext;
                    ACC_HIGH: mdio_rdata <= held_hi;
                    default:  mdio_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_bridge_chk.sv
// Module: mdio_bridge_chk
// Port-level protocol checks for the bridge, attached by bind.
module mdio_bridge_chk
    import mdio_bridge_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mdio_req,
    input logic                   mdio_wr,
    input logic [MDIO_ADDR_W-1:0] mdio_phy,
    input logic [MDIO_ADDR_W-1:0] mdio_reg,
    input logic                   mdio_rvalid,
    input logic [HALF_W-1:0]      mdio_rdata,
    input logic                   busy,
    input logic                   bus_req,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic                   bus_ready
);

    logic acc_ok;
    logic win;
    logic pg;

    // Decode as seen from the ports
    always_comb begin
        acc_ok = mdio_req && !busy;
        win    = (mdio_phy[MDIO_ADDR_W-1:WIN_SEL_W] == WIN_TAG);
        pg     = (mdio_phy == PAGE_PHY) && (mdio_reg == PAGE_REGNUM);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !bus_req && !mdio_rvalid && !busy); // R1
    AST_ADDR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && win && !mdio_reg[0] |=> bus_addr[WIN_SEL_W+PAIR_SEL_W+BYTE_OFS_W-1:0] == $past({mdio_phy[WIN_SEL_W-1:0], mdio_reg[PAIR_SEL_W:1], 2'b00})); // R3
    AST_HIGH_WR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && mdio_wr && win && mdio_reg[0] |=> !bus_req && !mdio_rvalid); // R4
    AST_LOW_WR_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && mdio_wr && win && !mdio_reg[0] |=> bus_req && bus_we); // R5
    AST_LOW_RD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && !mdio_wr && win && !mdio_reg[0] |=> bus_req && !bus_we && busy); // R6
    AST_HIGH_RD_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && !mdio_wr && win && mdio_reg[0] |=> mdio_rvalid && !bus_req); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R8
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> busy); // R8
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) bus_req && bus_ready |=> !bus_req && !busy); // R8
    AST_RD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ready && !bus_we |=> mdio_rvalid); // R8
    AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_ready |=> busy && !mdio_rvalid); // R9
    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && !mdio_wr && !win && !pg |=> mdio_rvalid && mdio_rdata == '0); // R10
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && mdio_wr |=> !mdio_rvalid); // R11

endmodule

bind mdio_wide_reg_bridge mdio_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdio_req    (mdio_req),
    .mdio_wr     (mdio_wr),
    .mdio_phy    (mdio_phy),
    .mdio_reg    (mdio_reg),
    .mdio_rvalid (mdio_rvalid),
    .mdio_rdata  (mdio_rdata),
    .busy        (busy),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ready   (bus_ready)
);

// File: tb/test_mdio_wide_reg_bridge.sv
module test_mdio_wide_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_req = 1'b0;
    logic        mdio_wr = 1'b0;
    logic [4:0]  mdio_phy = '0;
    logic [4:0]  mdio_reg = '0;
    logic [15:0] mdio_wdata = '0;
    logic        mdio_rvalid;
    logic [15:0] mdio_rdata;
    logic        busy;
    logic        bus_req;
    logic        bus_we;
    logic [17:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    mdio_wide_reg_bridge i_mdio_wide_reg_bridge (
        .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_rvalid(mdio_rvalid), .mdio_rdata(mdio_rdata), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic        we;
        logic [17:0] addr;
        logic [31:0] data;
        string       tag;
    } bus_item_t;

    typedef struct {
        logic [15:0] data;
        string       tag;
    } rd_item_t;

    bus_item_t bus_q[$];
    rd_item_t  rd_q[$];
    logic [31:0] ref_mem[logic [17:0]];
    logic [31:0] bus_mem[logic [17:0]];
    int n_cmp = 0;
    int n_bad = 0;
    int lat = 2;
    int wcnt = 0;
    logic [8:0]  m_page = '0;
    logic [15:0] m_stage = '0;
    logic [15:0] m_hold = '0;

    function automatic logic [31:0] seed_val(logic [17:0] a);
        return {a[15:0] ^ 16'h6B1D, a[17:2] ^ 16'hC3A0};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Driver: waits for idle, updates the reference model, pushes expectations
    task automatic mdio_acc(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd, string tag);
        logic        win;
        logic [17:0] a;
        logic [31:0] v;
        @(negedge clk);
        while (busy) @(negedge clk);
        win = (phy[4:3] == 2'b10);
        a = {m_page, phy[2:0], rg[4:1], 2'b00};
        if (wr) begin
            if (phy == 5'h1F && rg == 5'h10) m_page = wd[8:0];
            else if (win && rg[0]) m_stage = wd;
            else if (win) begin
                bus_q.push_back('{1'b1, a, {m_stage, wd}, tag});
                ref_mem[a] = {m_stage, wd};
            end
        end else begin
            if (phy == 5'h1F && rg == 5'h10) rd_q.push_back('{{7'b0, m_page}, tag});
            else if (win && rg[0]) rd_q.push_back('{m_hold, tag});
            else if (win) begin
                v = ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
                bus_q.push_back('{1'b0, a, 32'h0, tag});
                rd_q.push_back('{v[15:0], tag});
                m_hold = v[31:16];
            end else rd_q.push_back('{16'h0, tag});
        end
        mdio_wr = wr; mdio_phy = phy; mdio_reg = rg; mdio_wdata = wd; mdio_req = 1'b1;
        @(negedge clk);
        mdio_req = 1'b0;
    endtask

    // Raw request with no idle wait and no model update (dropped when busy)
    task automatic mdio_raw(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
        @(negedge clk);
        check("R9 busy while raw request", {31'b0, busy}, 32'h1);
        mdio_wr = wr; mdio_phy = phy; mdio_reg = rg; mdio_wdata = wd; mdio_req = 1'b1;
        @(negedge clk);
        mdio_req = 1'b0;
    endtask

    // Bus responder with programmable ready latency
    always begin
        @(negedge clk);
        if (bus_ready) begin
            bus_ready = 1'b0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                bus_ready = 1'b1;
                if (bus_we) begin
                    bus_mem[bus_addr] = bus_wdata;
                    bus_rdata = 32'h0;
                end else begin
                    bus_rdata = bus_mem.exists(bus_addr) ? bus_mem[bus_addr] : seed_val(bus_addr);
                end
            end else wcnt++;
        end
    end

    // Monitor: compares bus handshakes and read responses with the queues
    always begin
        bus_item_t b;
        rd_item_t  r;
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (bus_req && bus_ready) begin
                check("R8 busy during bus access", {31'b0, busy}, 32'h1);
                if (bus_q.size() == 0) check("R9 unexpected bus access", 32'h1, 32'h0);
                else begin
                    b = bus_q.pop_front();
                    check({b.tag, " R3 bus addr"}, {14'b0, bus_addr}, {14'b0, b.addr});
                    check({b.tag, " bus direction"}, {31'b0, bus_we}, {31'b0, b.we});
                    if (b.we) check({b.tag, " R5 bus wdata"}, bus_wdata, b.data);
                end
            end
            if (mdio_rvalid) begin
                if (rd_q.size() == 0) check("R11 unexpected response", 32'h1, 32'h0);
                else begin
                    r = rd_q.pop_front();
                    check({r.tag, " read data"}, {16'b0, mdio_rdata}, {16'b0, r.data});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R1 busy at reset", {31'b0, busy}, 32'h0);
        check("R1 bus_req at reset", {31'b0, bus_req}, 32'h0);
        check("R1 rvalid at reset", {31'b0, mdio_rvalid}, 32'h0);
        check("R1 rdata at reset", {16'b0, mdio_rdata}, 32'h0);

        // Low write with nothing staged: zero upper half, page zero
        mdio_acc(1, 5'h10, 5'h02, 16'h1234, "R1 R5 first low write");
        // Page register
        mdio_acc(1, 5'h1F, 5'h10, 16'hFFA5, "R2 page write");
        mdio_acc(0, 5'h1F, 5'h10, 16'h0, "R2 page read");
        // High then low write, then low then high read
        mdio_acc(1, 5'h13, 5'h07, 16'hBEEF, "R4 high write");
        mdio_acc(1, 5'h13, 5'h06, 16'hCAFE, "R5 low write commit");
        mdio_acc(0, 5'h13, 5'h06, 16'h0, "R6 low read");
        mdio_acc(0, 5'h13, 5'h07, 16'h0, "R7 high read");
        // Zero latency and an unwritten word at the top of the window
        lat = 0;
        mdio_acc(0, 5'h17, 5'h1E, 16'h0, "R6 R3 low read top");
        mdio_acc(0, 5'h17, 5'h1F, 16'h0, "R7 high read top");
        // Coherence: second low read replaces the held half
        lat = 5;
        mdio_acc(0, 5'h10, 5'h02, 16'h0, "R6 low read earlier word");
        mdio_acc(0, 5'h13, 5'h07, 16'h0, "R7 high read after reload");
        // Ignored accesses
        mdio_acc(1, 5'h05, 5'h00, 16'h7777, "R10 write outside");
        mdio_acc(1, 5'h1F, 5'h11, 16'h0033, "R10 write other page reg");
        mdio_acc(1, 5'h18, 5'h06, 16'h5555, "R10 write above window");
        mdio_acc(0, 5'h05, 5'h00, 16'h0, "R10 read outside");
        mdio_acc(0, 5'h1F, 5'h11, 16'h0, "R10 read other page reg");
        mdio_acc(0, 5'h0F, 5'h06, 16'h0, "R10 read below window");
        mdio_acc(0, 5'h1F, 5'h10, 16'h0, "R10 page unchanged");
        mdio_acc(0, 5'h13, 5'h06, 16'h0, "R10 word unchanged");
        // Requests while busy are dropped
        lat = 12;
        mdio_acc(1, 5'h10, 5'h01, 16'h1111, "R9 stage");
        mdio_acc(1, 5'h10, 5'h00, 16'h2222, "R9 first commit");
        mdio_raw(1, 5'h10, 5'h01, 16'h9999);
        mdio_raw(0, 5'h1F, 5'h10, 16'h0);
        mdio_raw(1, 5'h1F, 5'h10, 16'h0001);
        mdio_acc(1, 5'h10, 5'h00, 16'h3333, "R9 second commit keeps stage");
        mdio_acc(0, 5'h1F, 5'h10, 16'h0, "R9 page kept");
        mdio_acc(0, 5'h10, 5'h00, 16'h0, "R9 read back");
        mdio_acc(0, 5'h10, 5'h01, 16'h0, "R9 R7 read back high");

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R11 responses all seen", rd_q.size(), 32'h0);
        check("R8 bus accesses all seen", bus_q.size(), 32'h0);
        report();
    end

endmodule